// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

The block holds several independent down-counting interval timers behind a small word-addressed register bus. Each timer has a load register that holds its period minus one, and a control register with an enable bit and an auto-reload bit. All timers advance only on cycles where a shared slow tick enable is high. That tick arrives on the core clock at a fixed rate that does not depend on the core clock frequency.

The control write does three jobs. It arms the timer, it chooses one-shot or auto-reload, and it acknowledges the timer's level interrupt. When enable is written as one, the counter restarts from the load value. On the tick that finds the counter at zero, the timer raises its interrupt. In auto-reload mode it then reloads and keeps counting. In one-shot mode it parks at zero with enable still set, and it stays parked until the control register is written again. Software reads back the load value, the control bits and the live count.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset all interrupt outputs are low, and every timer's load, control and count registers read zero.
- R2: The load register of timer n is at byte address n*16 + 0. It keeps the low 23 bits of a write, and its upper read bits are zero.
- R3: The control register is at n*16 + 4. Bit 0 is enable and bit 1 is auto-reload. A control write with bit 0 set copies the load value into the counter, which reads back at n*16 + 8.
- R4: An enabled counter changes only on cycles where tick_en is high, and it drops by one per tick until it reaches zero.
- R5: With auto-reload clear, the interrupt rises on the tick that finds the count at zero, which is load+1 ticks after arming. After that the count holds at zero, the control register still reads enabled, and the interrupt stays high.
- R6: With auto-reload set, the expiring tick reloads the counter from the load register. The interrupt then recurs every load+1 ticks.
- R7: Any write to a timer's control register clears that timer's interrupt. Writing 3 keeps an auto-reload timer running.
- R8: Writing 0 to the control register stops the timer. Its count then stays frozen under ticks and its interrupt stays low.
- R9: A load write while a timer is running leaves the current count untouched. The new value is used only at the next reload or enabling write.
- R10: The timers are independent. A write to one timer's registers changes no other timer, and irq bit n belongs to timer n.
- R11: A timer index of 4 or more, or word offset 12, reads as zero, and writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per timer tick (fixed slow rate) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address: timer index in [7:4], word offset in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Level interrupt, one bit per timer |

## Verification
The bench builds the block with its default parameters: four timers, a 23-bit count and an 8-bit address. That makes every timer slot reachable, and it also makes out-of-range indices and the unused word offset reachable. It uses small load values, so one-shot expiry, repeated auto-reload periods and the load+1 tick count can all be observed tick by tick. The truncation to 23 bits is covered through load read-back, but a full-range countdown is not run.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types for the interval timer bank.
package tick_timer_pkg;
    localparam logic [1:0] OFF_LOAD  = 2'd0;
    localparam logic [1:0] OFF_CTRL  = 2'd1;
    localparam logic [1:0] OFF_COUNT = 2'd2;

    // Control register layout: bit 1 auto-reload, bit 0 enable.
    typedef struct packed {
        logic reload;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/tick_timer_decode.sv
// Address decoder: turns a bus write into per-timer load/control strobes.
// Assumes timer n occupies bytes n*16..n*16+15; unknown offsets are dropped.
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [NUM_TIMERS-1:0] load_we,
    output logic [NUM_TIMERS-1:0] ctrl_we
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [1:0]       off;
    logic             unused_addr_lo;

    assign idx            = bus_addr[ADDR_W-1:4];
    assign off            = bus_addr[3:2];
    assign unused_addr_lo = ^bus_addr[1:0];

    // One strobe pair per timer slot.
    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_strobe
        assign load_we[n] = bus_we && (idx == IDX_W'(n)) && (off == OFF_LOAD);
        assign ctrl_we[n] = bus_we && (idx == IDX_W'(n)) && (off == OFF_CTRL);
    end
endmodule

// File: rtl/tick_timer_chan.sv
// One interval timer: load register, control bits, down counter, interrupt.
// Assumes load and control writes for this channel never coincide.
module tick_timer_chan
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_we,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic [1:0]       ctrl_wdata,
    output logic [CNT_W-1:0] load_q,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    logic parked;   // one-shot expired, waiting for a control rewrite

    // Load register: updated only by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (load_we) load_q <= load_wdata;
    end

    // Control, counter and interrupt state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            count_q <= '0;
            irq     <= 1'b0;
            parked  <= 1'b0;
        end else if (ctrl_we) begin
            ctrl_q.enable <= ctrl_wdata[0];
            ctrl_q.reload <= ctrl_wdata[1];
            irq           <= 1'b0;
            parked        <= 1'b0;
            if (ctrl_wdata[0]) count_q <= load_q;
        end else if (tick_en && ctrl_q.enable && !parked) begin
            if (count_q == '0) begin
                irq <= 1'b1;
                if (ctrl_q.reload) count_q <= load_q;
                else               parked  <= 1'b1;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // R3: an enabling control write restarts from the load value.
    p_enable_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[0]) |=> (count_q == $past(load_q)));

    // R4: without a tick or control write the count cannot move.
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ctrl_we) |=> $stable(count_q));

    // R5: the interrupt rises only on a tick that found an enabled zero count.
    p_irq_rise_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en && ctrl_q.enable && count_q == '0));

    // R5: a parked one-shot stays at zero, enabled, with interrupt held.
    p_oneshot_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !ctrl_we) |=> (count_q == '0 && irq && ctrl_q.enable));

    // R7: any control write acknowledges the interrupt.
    p_ctrl_clears_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !irq);

    // R8: a stopped timer neither counts nor interrupts.
    p_stopped_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.enable && !ctrl_we) |=> ($stable(count_q) && !$rose(irq)));
endmodule

// File: rtl/tick_timer_rdmux.sv
// Read-back multiplexer: selects a timer register by address, zero elsewhere.
module tick_timer_rdmux
    import tick_timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int CNT_W      = 23,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  load_q,
    input  ctrl_t [NUM_TIMERS-1:0]            ctrl_q,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  count_q,
    output logic [DATA_W-1:0]                 bus_rdata
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [1:0]       off;

    assign idx = bus_addr[ADDR_W-1:4];
    assign off = bus_addr[3:2];

    // Pick the addressed register; unmatched addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_TIMERS; n++) begin
            if (idx == IDX_W'(n)) begin
                case (off)
                    OFF_LOAD:  bus_rdata = DATA_W'(load_q[n]);
                    OFF_CTRL:  bus_rdata = DATA_W'(ctrl_q[n]);
                    OFF_COUNT: bus_rdata = DATA_W'(count_q[n]);
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tick_timer_bank.sv
// Top: a bank of independent interval timers on a simple register bus.
// Assumes tick_en is a single-cycle pulse synchronous to clk; DATA_W > CNT_W.
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int CNT_W      = 23,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    logic [NUM_TIMERS-1:0]            load_we;
    logic [NUM_TIMERS-1:0]            ctrl_we;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] load_q;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] count_q;
    ctrl_t [NUM_TIMERS-1:0]           ctrl_q;
    logic                             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    tick_timer_decode #(
        .NUM_TIMERS(NUM_TIMERS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .load_we (load_we),
        .ctrl_we (ctrl_we)
    );

    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_chan
        tick_timer_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .load_we   (load_we[n]),
            .ctrl_we   (ctrl_we[n]),
            .load_wdata(bus_wdata[CNT_W-1:0]),
            .ctrl_wdata(bus_wdata[1:0]),
            .load_q    (load_q[n]),
            .ctrl_q    (ctrl_q[n]),
            .count_q   (count_q[n]),
            .irq       (irq[n])
        );
    end

    tick_timer_rdmux #(
        .NUM_TIMERS(NUM_TIMERS),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_rdmux (
        .bus_addr (bus_addr),
        .load_q   (load_q),
        .ctrl_q   (ctrl_q),
        .count_q  (count_q),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/tick_timer_bank_tb.sv
// Directed bench for the interval timer bank.
module tick_timer_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        for (int n = 0; n < 4; n++) begin
            rd(8'(n*16), v);     chk("R1 load", v, 0);
            rd(8'(n*16 + 4), v); chk("R1 ctrl", v, 0);
            rd(8'(n*16 + 8), v); chk("R1 count", v, 0);
        end
    endtask

    task automatic t_load_readback;
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R2 load truncated", v, 32'h007F_FFFF);
        wr(8'h10, 32'd5);
        rd(8'h10, v); chk("R2 load value", v, 5);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(8'h00, 32'd4);
        wr(8'h04, 32'd1);
        rd(8'h08, v); chk("R3 armed count", v, 4);
        repeat (5) @(negedge clk);
        rd(8'h08, v); chk("R4 no tick hold", v, 4);
        ticks(2);
        rd(8'h08, v); chk("R4 decrement", v, 2);
        ticks(2);
        rd(8'h08, v); chk("R4 reached zero", v, 0);
        chk("R5 no irq before expiry", 32'(irq[0]), 0);
        ticks(1);
        chk("R5 irq after load+1", 32'(irq[0]), 1);
        ticks(3);
        rd(8'h08, v); chk("R5 parked count", v, 0);
        rd(8'h04, v); chk("R5 still enabled", v, 1);
        chk("R5 irq held", 32'(irq[0]), 1);
        wr(8'h04, 32'd0);
        chk("R7 ack clears", 32'(irq[0]), 0);
        ticks(3);
        chk("R8 no irq stopped", 32'(irq[0]), 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(8'h20, 32'd2);
        wr(8'h24, 32'd3);
        ticks(3);
        chk("R6 first expiry", 32'(irq[2]), 1);
        rd(8'h28, v); chk("R6 reloaded", v, 2);
        wr(8'h24, 32'd3);
        chk("R7 ack periodic", 32'(irq[2]), 0);
        ticks(2);
        chk("R6 not yet", 32'(irq[2]), 0);
        ticks(1);
        chk("R6 second expiry", 32'(irq[2]), 1);
        wr(8'h20, 32'd5);
        rd(8'h28, v); chk("R9 count kept", v, 2);
        ticks(1);
        rd(8'h28, v); chk("R9 old period continues", v, 1);
        ticks(2);
        rd(8'h28, v); chk("R9 new load at reload", v, 5);
        wr(8'h24, 32'd3);
        chk("R7 ack again", 32'(irq[2]), 0);
        ticks(5);
        chk("R6 period six not yet", 32'(irq[2]), 0);
        ticks(1);
        chk("R6 period six", 32'(irq[2]), 1);
        wr(8'h24, 32'd0);
        chk("R7 stop ack", 32'(irq[2]), 0);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(8'h30, 32'd10);
        wr(8'h34, 32'd1);
        ticks(3);
        rd(8'h38, v); chk("R8 running", v, 7);
        wr(8'h34, 32'd0);
        ticks(20);
        rd(8'h38, v); chk("R8 frozen", v, 7);
        rd(8'h34, v); chk("R8 ctrl zero", v, 0);
        chk("R8 irq low", 32'(irq[3]), 0);
    endtask

    task automatic t_indep;
        logic [31:0] v;
        wr(8'h10, 32'd1);
        wr(8'h00, 32'd3);
        wr(8'h14, 32'd1);
        wr(8'h04, 32'd1);
        ticks(2);
        chk("R10 only timer1", 32'(irq), 32'h2);
        rd(8'h08, v); chk("R10 timer0 count", v, 1);
        rd(8'h38, v); chk("R10 timer3 untouched", v, 7);
        ticks(2);
        chk("R10 both fired", 32'(irq), 32'h3);
    endtask

    task automatic t_out_of_range;
        logic [31:0] v;
        wr(8'h40, 32'd9);
        wr(8'h44, 32'd3);
        rd(8'h40, v); chk("R11 index4 load", v, 0);
        rd(8'h44, v); chk("R11 index4 ctrl", v, 0);
        wr(8'h0C, 32'd0);
        rd(8'h0C, v); chk("R11 offset12", v, 0);
        chk("R11 irq unchanged", 32'(irq), 32'h3);
        rd(8'h00, v); chk("R11 timer0 load kept", v, 3);
        rd(8'h04, v); chk("R11 timer0 ctrl kept", v, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_readback();
        t_oneshot();
        t_periodic();
        t_stop();
        t_indep();
        t_out_of_range();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule